// File: doc/BRIEF.md
# Inversion-Coded Differential Write Unit

This block stands in front of an array of non-volatile cells and decides, for each write, which cells actually need a programming pulse. Every stored word carries one extra flag cell that records whether the data bits hold the true value or its complement. A write first fetches the old word and flag. It then works out how many cells each of the two possible encodings would disturb, counting the flag cell as well. It keeps whichever encoding disturbs fewer cells, and on a tie it keeps the true form.

Only cells whose stored value differs from the chosen encoding are programmed. The block drives two separate masks. One marks the cells that must go from 0 to 1, which take the long, moderate pulse. The other marks the cells that must go from 1 to 0, which take the short, strong pulse. A read fetches the stored word and removes the inversion before returning the data.

The cell array is modelled inside the block as a small synchronous memory that clears to all zeros on reset. Requests are accepted only while the block is idle. A `busy` output covers the whole operation.

Top module: `flip_write_unit`

## Requirements
- R1: After reset, `busy`, `prog_valid` and `rd_valid` are 0, both masks are 0, and every address reads back as data 0.
- R2: A write accepted on a clock edge raises `busy` for exactly three cycles: fetch, compute, program. `prog_valid` is high only in the third of these, and `busy` falls on the following edge.
- R3: During programming, the union of the two masks is exactly the set of cells in which the stored word (data plus flag) differs from the newly chosen encoding. Outside programming both masks are 0.
- R4: `set_mask` bit i is 1 only for a cell going from 0 to 1, and `reset_mask` bit i is 1 only for a cell going from 1 to 0. The two masks never overlap. Mask bits DATA_W-1..0 are the data cells and bit DATA_W is the flag cell.
- R5: The inverted encoding, which is flag 1 with the data complemented, is chosen when it changes strictly fewer cells than the true encoding, which is flag 0 with the data as given. The flag cell counts in both costs.
- R6: When both encodings change the same number of cells, the true encoding is stored.
- R7: `prog_count` equals the number of ones in the two masks together, and it never exceeds (DATA_W+1)/2 rounded down.
- R8: A read accepted on an edge keeps `busy` high for two cycles. `rd_valid` then pulses for one cycle with `rd_data` equal to the stored data XOR the replicated flag, which is the last value written to that address. A read programs no cell.
- R9: A request presented while `busy` is high is ignored and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Operation in progress |
| rd_valid | output | 1 | One-cycle pulse, read data ready |
| rd_data | output | DATA_W | Decoded read data |
| prog_valid | output | 1 | Program phase, masks are meaningful |
| set_mask | output | DATA_W+1 | Cells to drive from 0 to 1 |
| reset_mask | output | DATA_W+1 | Cells to drive from 1 to 0 |
| prog_count | output | $clog2(DATA_W+2) | Number of cells programmed by this write |

## Verification
The hardest case to reach from the ports is a tie between the two encodings, together with a flag cell that is already set. A tie needs an even total cell count, which is why the default data width is odd. Any old content that is already inverted makes the flag cell part of the cost. A scripted sequence first stores a word with eight ones on a cleared address, then overwrites it with zero, so that both writes land exactly on a tie. Other entries store a nearly full word, which leaves the flag set, and then rewrite it, so the flag's own cost decides the choice. A pseudo-random run then compares the masks against a bench-side cost model, and a request held high during a write checks that nothing is taken while busy.

// File: rtl/fwu_pkg.sv
package fwu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CALC  = 2'd2,
    ST_PROG  = 2'd3
  } fwu_state_e;

  // number of set bits in a vector of up to 64 bits
  function automatic logic [6:0] ones64(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) begin
      n = n + 7'(v[i]);
    end
    return n;
  endfunction

endpackage

// File: rtl/fwu_cell_array.sv
module fwu_cell_array #(
  parameter int DATA_W = 15,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W:0]     rd_word,
  input  logic                pg_en,
  input  logic [ADDR_W-1:0]   pg_addr,
  input  logic [DATA_W:0]     pg_set,
  input  logic [DATA_W:0]     pg_clr
);
  localparam int WORD_W = DATA_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (pg_en) begin
      cells[pg_addr] <= (cells[pg_addr] | pg_set) & ~pg_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_word <= '0;
    else if (rd_en) rd_word <= cells[rd_addr];
  end

  // a cell may not receive both pulses at once
  assert_no_dual_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pg_en |-> ((pg_set & pg_clr) == '0));

endmodule

// File: rtl/fwu_encoder.sv
module fwu_encoder #(
  parameter int DATA_W = 15,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W:0]   old_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W:0]   new_word,
  output logic [DATA_W:0]   up_mask,
  output logic [DATA_W:0]   down_mask,
  output logic [CNT_W-1:0]  flips,
  output logic              use_inv
);
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] cand_true, cand_inv;
  logic [WORD_W-1:0] diff_true, diff_inv;
  logic [CNT_W-1:0]  cost_true, cost_inv;

  assign cand_true = {1'b0, wdata};
  assign cand_inv  = {1'b1, ~wdata};
  assign diff_true = cand_true ^ old_word;
  assign diff_inv  = cand_inv  ^ old_word;

  assign cost_true = CNT_W'(fwu_pkg::ones64(64'(diff_true)));
  assign cost_inv  = CNT_W'(fwu_pkg::ones64(64'(diff_inv)));

  // strict compare: a tie keeps the true form
  assign use_inv   = cost_inv < cost_true;
  assign new_word  = use_inv ? cand_inv : cand_true;
  assign flips     = use_inv ? cost_inv : cost_true;
  assign up_mask   = new_word & ~old_word;
  assign down_mask = ~new_word & old_word;

endmodule

// File: rtl/fwu_sequencer.sv
module fwu_sequencer #(
  parameter int DATA_W = 15,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              ph_fetch,
  output logic              ph_calc,
  output logic              ph_prog,
  output logic              op_write,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata
);
  import fwu_pkg::*;

  fwu_state_e state_q, state_d;
  logic       accept;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_CALC;
      ST_CALC:  state_d = op_write ? ST_PROG : ST_IDLE;
      ST_PROG:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_write <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_write <= req_write;
        op_addr  <= req_addr;
        op_wdata <= req_wdata;
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign ph_fetch = (state_q == ST_FETCH);
  assign ph_calc  = (state_q == ST_CALC);
  assign ph_prog  = (state_q == ST_PROG);

  assert_calc_after_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_calc |-> $past(ph_fetch));
  assert_prog_after_calc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_prog |-> $past(ph_calc));
  assert_op_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(accept)) |-> $stable(op_addr) && $stable(op_wdata));

endmodule

// File: rtl/flip_write_unit.sv
module flip_write_unit #(
  parameter int DATA_W = 15,
  parameter int ADDR_W = 4,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              prog_valid,
  output logic [DATA_W:0]   set_mask,
  output logic [DATA_W:0]   reset_mask,
  output logic [CNT_W-1:0]  prog_count
);
  localparam int WORD_W   = DATA_W + 1;
  localparam int HALF_CNT = WORD_W / 2;

  logic              ph_fetch, ph_calc, ph_prog, op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [WORD_W-1:0] stored_word, enc_word, enc_up, enc_down;
  logic [CNT_W-1:0]  enc_flips;
  logic              enc_inv;
  logic [DATA_W-1:0] decoded;

  fwu_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .ph_fetch(ph_fetch), .ph_calc(ph_calc), .ph_prog(ph_prog),
    .op_write(op_write), .op_addr(op_addr), .op_wdata(op_wdata)
  );

  fwu_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) arr_i (
    .clk(clk), .rst_n(rst_n),
    .rd_en(ph_fetch), .rd_addr(op_addr), .rd_word(stored_word),
    .pg_en(prog_valid), .pg_addr(op_addr),
    .pg_set(set_mask), .pg_clr(reset_mask)
  );

  fwu_encoder #(.DATA_W(DATA_W), .CNT_W(CNT_W)) enc_i (
    .old_word(stored_word), .wdata(op_wdata),
    .new_word(enc_word), .up_mask(enc_up), .down_mask(enc_down),
    .flips(enc_flips), .use_inv(enc_inv)
  );

  assign decoded    = stored_word[DATA_W-1:0] ^ {DATA_W{stored_word[DATA_W]}};
  assign prog_valid = ph_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_mask   <= '0;
      reset_mask <= '0;
      prog_count <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= ph_calc && !op_write;
      if (ph_calc && !op_write) rd_data <= decoded;
      if (ph_calc && op_write) begin
        set_mask   <= enc_up;
        reset_mask <= enc_down;
        prog_count <= enc_flips;
      end else begin
        set_mask   <= '0;
        reset_mask <= '0;
        prog_count <= '0;
      end
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> (prog_count <= CNT_W'(HALF_CNT)));
  assert_count_matches_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> ($countones(set_mask | reset_mask) == int'(prog_count)));
  assert_masks_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_valid |-> (set_mask == '0 && reset_mask == '0));
  assert_prog_under_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> busy);
  assert_prog_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |=> !busy);
  assert_read_no_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && prog_valid));
  assert_read_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/flip_write_unit_tb_top.sv
`timescale 1ns/1ps
module flip_write_unit_tb_top;
  localparam int DW = 15;
  localparam int AW = 4;
  localparam int CW = $clog2(DW + 2);
  localparam int WW = DW + 1;
  localparam real CLK_NS = 8.0;
  localparam int NVEC = 13;

  // {write, addr, data (expected data for reads), expect_inverted, expected count}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 4'd1, 15'h0000, 1'b0, 4'd0},
    {1'b1, 4'd2, 15'h7FFF, 1'b1, 4'd1},
    {1'b0, 4'd2, 15'h7FFF, 1'b0, 4'd0},
    {1'b1, 4'd3, 15'h00FF, 1'b0, 4'd8},
    {1'b1, 4'd3, 15'h0000, 1'b0, 4'd8},
    {1'b1, 4'd4, 15'h0001, 1'b0, 4'd1},
    {1'b1, 4'd2, 15'h0000, 1'b0, 4'd1},
    {1'b0, 4'd2, 15'h0000, 1'b0, 4'd0},
    {1'b1, 4'd5, 15'h7FFE, 1'b1, 4'd2},
    {1'b0, 4'd5, 15'h7FFE, 1'b0, 4'd0},
    {1'b1, 4'd5, 15'h7FFF, 1'b1, 4'd1},
    {1'b0, 4'd5, 15'h7FFF, 1'b0, 4'd0},
    {1'b0, 4'd1, 15'h0000, 1'b0, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, rd_valid, prog_valid;
  logic [DW-1:0] rd_data;
  logic [DW:0] set_mask, reset_mask;
  logic [CW-1:0] prog_count;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [WW-1:0] shadow [1 << AW];

  always #(CLK_NS / 2.0) clk = ~clk;

  flip_write_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .prog_valid(prog_valid),
    .set_mask(set_mask), .reset_mask(reset_mask), .prog_count(prog_count)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one request, sampling each phase at the falling edge
  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [WW-1:0] s, output logic [WW-1:0] r,
                        output logic [CW-1:0] c, output logic [DW-1:0] rdat, output bit seq_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    seq_ok = busy && !prog_valid;
    @(negedge clk);
    seq_ok &= busy && !prog_valid && !rd_valid;
    @(negedge clk);
    s = set_mask; r = reset_mask; c = prog_count; rdat = rd_data;
    if (wr) begin
      seq_ok &= busy && prog_valid && !rd_valid;
      @(negedge clk);
      seq_ok &= !busy && !prog_valid;
    end else begin
      seq_ok &= !busy && rd_valid && !prog_valid && (set_mask == '0) && (reset_mask == '0);
      @(negedge clk);
      seq_ok &= !rd_valid;
    end
  endtask

  function automatic int diff_cells(input logic [WW-1:0] x, input logic [WW-1:0] y);
    int n = 0;
    for (int i = 0; i < WW; i++) if (x[i] != y[i]) n++;
    return n;
  endfunction

  task automatic check_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit inv,
                             input logic [WW-1:0] s, input logic [WW-1:0] r, input logic [CW-1:0] c);
    logic [WW-1:0] old_w, new_w;
    old_w = shadow[a];
    new_w = inv ? {1'b1, ~d} : {1'b0, d};
    check(s == (new_w & ~old_w), "R4 set mask", 32'(s), 32'(new_w & ~old_w));
    check(r == (old_w & ~new_w), "R4 reset mask", 32'(r), 32'(old_w & ~new_w));
    check((s | r) == (old_w ^ new_w), "R3 only differing cells", 32'(s | r), 32'(old_w ^ new_w));
    check(int'(c) <= WW / 2, "R7 count bound", 32'(c), 32'(WW / 2));
    shadow[a] = new_w;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] s, r;
    logic [CW-1:0] c;
    logic [DW-1:0] rd;
    bit sok;
    logic [15:0] lfsr;
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !prog_valid && !rd_valid, "R1 idle flags", {busy, prog_valid, rd_valid}, 0);
    check(set_mask == '0 && reset_mask == '0, "R1 masks clear", 32'(set_mask | reset_mask), 0);
    run_op(1'b0, 4'd15, '0, s, r, c, rd, sok);
    check(rd == '0, "R1 cleared cells read zero", 32'(rd), 0);
    check(sok, "R8 read phase timing", 32'(sok), 1);

    // scripted vectors: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      logic [24:0] v;
      v = VEC[k];
      run_op(v[24], v[23:20], v[19:5], s, r, c, rd, sok);
      check(sok, v[24] ? "R2 write phase timing" : "R8 read phase timing", 32'(sok), 1);
      if (v[24]) begin
        check(int'(c) == int'(v[3:0]), "R5 R6 programmed count", 32'(c), 32'(v[3:0]));
        check_write(v[23:20], v[19:5], v[4], s, r, c);
      end else begin
        check(rd == v[19:5], "R8 decoded read data", 32'(rd), 32'(v[19:5]));
      end
    end

    // R9: request held high while a write is in progress
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd6; req_wdata = 15'h0F0F;
    @(negedge clk);
    req_addr = 4'd9; req_wdata = 15'h1234;
    @(negedge clk);
    @(negedge clk);
    check(prog_valid && int'(prog_count) == 8, "R6 tie on fresh word", 32'(prog_count), 8);
    check_write(4'd6, 15'h0F0F, 1'b0, set_mask, reset_mask, prog_count);
    req_valid = 1'b0;
    @(negedge clk);
    run_op(1'b0, 4'd9, '0, s, r, c, rd, sok);
    check(rd == '0, "R9 busy request ignored", 32'(rd), 0);
    run_op(1'b0, 4'd6, '0, s, r, c, rd, sok);
    check(rd == 15'h0F0F, "R9 original write intact", 32'(rd), 32'h0F0F);

    // pseudo-random writes against an independent cost model: R3 R4 R5 R7
    lfsr = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int ct, ci;
      bit inv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[3:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = (k % 3 == 0) ? ~lfsr[14:0] : lfsr[14:0];
      ct = diff_cells(shadow[a], {1'b0, d});
      ci = diff_cells(shadow[a], {1'b1, ~d});
      inv = ci < ct;
      run_op(1'b1, a, d, s, r, c, rd, sok);
      check(sok, "R2 write phase timing", 32'(sok), 1);
      check(int'(c) == (inv ? ci : ct), "R5 cheaper encoding count", 32'(c), 32'(inv ? ci : ct));
      check_write(a, d, inv, s, r, c);
      run_op(1'b0, a, '0, s, r, c, rd, sok);
      check(rd == d, "R8 read after random write", 32'(rd), 32'(d));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule